// File: doc/BRIEF.md
# Thermal Trip Monitor

This block watches the newest temperature code of every sensor channel and raises events when a channel runs hot. Codes are 12 bits wide and run opposite to temperature: a smaller code means a hotter die. Each channel has two limits. The first is an alarm limit paired with a release code, which gives the alarm hysteresis. The second is a shutdown limit, which has no hysteresis.

Events are held in sticky status bits. Software acknowledges them by writing ones to those bits. A single interrupt line is the OR of every pending status bit whose enable is set. Software reaches the limits, the enables and the status through a simple register port. Writes take effect at the clock edge. Reads return data combinationally from the address presented.

The code inputs form one stream per channel, with a valid strobe and a ready output. Ready is held high at all times, so the block never applies back-pressure. A code is consumed in every cycle in which its valid is high.

Top module: `thermal_trip_monitor`

## Requirements
- R1: After reset, every limit register, the enable register and the status register read zero, and `irq` is low.
- R2: Channel i has an alarm register at 0x50+4*i, which holds the hot code in bits 27:16 and the release code in bits 11:0. It has a shutdown register at 0x60+4*i, which holds its limit in bits 27:16. The enable register is at 0x44 and the status register is at 0x48. Unused bits and unmapped addresses read zero.
- R3: A channel enters its alarm state when a valid code is at or below a nonzero hot code. Status bit i sets only on this entry.
- R4: An active alarm stays active until a valid code is at or above the release code. While the alarm is active, further hot codes do not set the status bit again. After release, the next hot code sets it again.
- R5: Status bit 4+i sets on every valid code of channel i that is at or below a nonzero shutdown limit.
- R6: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R7: If an event and a write-1 clear reach the same status bit in the same cycle, the bit stays set.
- R8: `irq` is high exactly when some status bit is set and the enable bit at the same position is set.
- R9: A hot code or shutdown limit of zero disables that comparison.
- R10: `code_ready` is always high. A code whose valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | NUM_CH | Per-channel code strobe |
| code_ready | output | NUM_CH | Per-channel accept, always high |
| code_data | input | NUM_CH*12 | Packed codes, channel i in bits 12*i+11:12*i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The assertions check three things on every cycle. Any event sets its status bit at the next edge, even when a clear hits that bit in the same cycle. A status bit falls only under a write of 1. `irq` never rises without an enabled pending bit. At the channel level, they check that a hot code enters the alarm state, that the alarm holds below the release code, and that a zero hot code keeps the channel idle. The bench sweeps codes across the shutdown, hot and release limits on every channel and compares each step against an arithmetic model. Only those scenarios can show that no status bit is set twice during one alarm episode, that the register layout and read-back are correct, and how partial enables affect the interrupt.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;
  localparam int CODE_W   = 12;
  localparam int REG_AW   = 8;
  localparam int REG_DW   = 32;
  localparam int HOT_LSB  = 16;
  localparam int REL_LSB  = 0;
  localparam int SHUT_POS = 4;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h44;
  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h48;
  localparam logic [REG_AW-1:0] OFS_ALARM  = 8'h50;
  localparam logic [REG_AW-1:0] OFS_SHUT   = 8'h60;

  typedef struct packed {
    logic [CODE_W-1:0] hot;
    logic [CODE_W-1:0] release_code;
    logic [CODE_W-1:0] shut;
  } trip_cfg_t;
endpackage

// File: rtl/thermal_trip_regs.sv
module thermal_trip_regs
  import thermal_trip_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int STAT_W = SHUT_POS + NUM_CH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   addr,
  input  logic [REG_DW-1:0]   wdata,
  input  logic [STAT_W-1:0]   status,
  output trip_cfg_t           cfg [NUM_CH],
  output logic [STAT_W-1:0]   enable,
  output logic [REG_DW-1:0]   rdata
);
  localparam logic [STAT_W-1:0] SRC_MASK =
    STAT_W'(((1 << NUM_CH) - 1) | (((1 << NUM_CH) - 1) << SHUT_POS));

  always_ff @(posedge clk) begin
    if (!rst_n) enable <= '0;
    else if (wr_en && addr == OFS_ENABLE) enable <= wdata[STAT_W-1:0] & SRC_MASK;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    localparam logic [REG_AW-1:0] A_ADDR = OFS_ALARM + REG_AW'(4 * c);
    localparam logic [REG_AW-1:0] S_ADDR = OFS_SHUT + REG_AW'(4 * c);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[c] <= '0;
      end else if (wr_en) begin
        if (addr == A_ADDR) begin
          cfg[c].hot          <= wdata[HOT_LSB +: CODE_W];
          cfg[c].release_code <= wdata[REL_LSB +: CODE_W];
        end
        if (addr == S_ADDR) cfg[c].shut <= wdata[HOT_LSB +: CODE_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_ENABLE) rdata[STAT_W-1:0] = enable;
    if (addr == OFS_STATUS) rdata[STAT_W-1:0] = status;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == OFS_ALARM + REG_AW'(4 * c)) begin
        rdata[HOT_LSB +: CODE_W] = cfg[c].hot;
        rdata[REL_LSB +: CODE_W] = cfg[c].release_code;
      end
      if (addr == OFS_SHUT + REG_AW'(4 * c)) rdata[HOT_LSB +: CODE_W] = cfg[c].shut;
    end
  end
endmodule

// File: rtl/thermal_trip_chan.sv
module thermal_trip_chan
  import thermal_trip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  input  trip_cfg_t         cfg,
  output logic              alarm_evt,
  output logic              shut_evt
);
  logic active;
  logic hot_on, at_hot, cooled;

  always_comb begin
    hot_on    = cfg.hot != '0;
    at_hot    = code <= cfg.hot;
    cooled    = code >= cfg.release_code;
    alarm_evt = valid && hot_on && !active && at_hot;
    shut_evt  = valid && (cfg.shut != '0) && (code <= cfg.shut);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !hot_on) active <= 1'b0;
    else if (valid) begin
      if (active && cooled) active <= 1'b0;
      else if (!active && at_hot) active <= 1'b1;
    end
  end

  // R3: a hot code on an idle, enabled channel enters the alarm state
  a_r3_enter_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cfg.hot != '0 && !active && code <= cfg.hot) |=> active);
  // R4: the alarm holds while codes stay below the release code
  a_r4_hold_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cfg.hot != '0 && valid && code < cfg.release_code) |=> active);
  // R9: a zero hot code keeps the channel idle
  a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.hot == '0) |=> !active);
endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor
  import thermal_trip_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        code_valid,
  output logic [NUM_CH-1:0]        code_ready,
  input  logic [NUM_CH*CODE_W-1:0] code_data,
  input  logic                     reg_wr,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [REG_DW-1:0]        reg_wdata,
  output logic [REG_DW-1:0]        reg_rdata,
  output logic                     irq
);
  localparam int STAT_W = SHUT_POS + NUM_CH;

  trip_cfg_t         cfg [NUM_CH];
  logic [STAT_W-1:0] enable, status, evt, clr;
  logic [NUM_CH-1:0] alarm_evt, shut_evt;

  assign code_ready = '1;

  thermal_trip_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .cfg(cfg), .enable(enable), .rdata(reg_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    thermal_trip_chan u_chan (
      .clk(clk), .rst_n(rst_n), .valid(code_valid[c]),
      .code(code_data[c*CODE_W +: CODE_W]), .cfg(cfg[c]),
      .alarm_evt(alarm_evt[c]), .shut_evt(shut_evt[c])
    );
  end

  always_comb begin
    evt = '0;
    evt[NUM_CH-1:0] = alarm_evt;
    evt[SHUT_POS +: NUM_CH] = shut_evt;
    clr = (reg_wr && reg_addr == OFS_STATUS) ? reg_wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else status <= (status & ~clr) | evt;
  end

  assign irq = |(status & enable);

  // R7: an event always lands, even against a same-cycle clear
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
  // R6: a status bit falls only under a write of 1
  a_r6_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~status) & ~$past(clr)) == '0));
  // R8: no interrupt without an enabled pending bit
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & enable) != '0));
endmodule

// File: tb/thermal_trip_monitor_bench.sv
module thermal_trip_monitor_bench;
  localparam int NCH = 3;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] code_valid = '0;
  logic [NCH-1:0] code_ready;
  logic [NCH*12-1:0] code_data = '0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic [7:0] mst;
  logic act [NCH];

  always #2 clk = ~clk;

  thermal_trip_monitor #(.NUM_CH(NCH)) u_thermal_trip_monitor (.*);

  task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic send(int ch, logic [11:0] c);
    @(negedge clk); code_valid[ch] = 1; code_data[ch*12 +: 12] = c;
    @(posedge clk); @(negedge clk); code_valid[ch] = 0;
  endtask

  function automatic void model(int ch, logic [11:0] c, logic [11:0] hot,
                                logic [11:0] rel, logic [11:0] sh);
    if (hot == 0) act[ch] = 0;
    else if (act[ch]) begin if (c >= rel) act[ch] = 0; end
    else if (c <= hot) begin act[ch] = 1; mst[ch] = 1; end
    if (sh != 0 && c <= sh) mst[4+ch] = 1;
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    mst = '0;
    for (int i = 0; i < NCH; i++) act[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state, R10 ready
    for (int i = 0; i < NCH; i++) begin
      rd(8'h50 + 8'(4*i), d); chk("R1 alarm reg", d, 0);
      rd(8'h60 + 8'(4*i), d); chk("R1 shut reg", d, 0);
    end
    rd(8'h44, d); chk("R1 enable", d, 0);
    rd(8'h48, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R10 ready", {29'b0, code_ready}, 3'b111);
    // R2 layout and masking
    wr(8'h54, 32'hFABC_F123); rd(8'h54, d); chk("R2 alarm fields", d, 32'h0ABC_0123);
    wr(8'h68, 32'hFFFF_FFFF); rd(8'h68, d); chk("R2 shut field", d, 32'h0FFF_0000);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, d); chk("R2 enable mask", d, 32'h77);
    rd(8'h4C, d); chk("R2 unmapped", d, 0);
    wr(8'h68, 0); wr(8'h54, 0);
    // R3 R4 R5 R8 sweep across limits, every channel
    for (int ch = 0; ch < NCH; ch++) begin
      logic [11:0] hot, rel, sh;
      hot = 12'h400 - 12'(ch*32); rel = 12'h480; sh = 12'h300 + 12'(ch*16);
      wr(8'h50 + 8'(4*ch), {4'b0, hot, 4'b0, rel});
      wr(8'h60 + 8'(4*ch), {4'b0, sh, 16'b0});
      for (int k = 0; k < 80; k++) begin
        logic [11:0] c;
        c = 12'h2C0 + 12'((k*37 + ch*11) % 512);
        send(ch, c);
        model(ch, c, hot, rel, sh);
        rd(8'h48, d); chk("R3 R4 R5 status sweep", d, {24'b0, mst});
        chk("R8 irq sweep", {31'b0, irq}, {31'b0, mst != 0});
        if (k % 5 == 4) begin wr(8'h48, 32'h77); mst = 0; end
      end
      wr(8'h50 + 8'(4*ch), 0); wr(8'h60 + 8'(4*ch), 0); act[ch] = 0;
    end
    wr(8'h48, 32'h77); mst = 0;
    // R4 explicit re-entry on channel 0
    wr(8'h50, {4'b0, 12'h200, 4'b0, 12'h280});
    send(0, 12'h1F0); rd(8'h48, d); chk("R4 first entry", d, 32'h01);
    wr(8'h48, 32'h01);
    send(0, 12'h100); send(0, 12'h27F); rd(8'h48, d); chk("R4 no re-set while active", d, 0);
    send(0, 12'h280); send(0, 12'h200); rd(8'h48, d); chk("R4 re-entry after release", d, 32'h01);
    // R6 write 0 keeps, write 1 clears
    wr(8'h48, 32'h0); rd(8'h48, d); chk("R6 write zero", d, 32'h01);
    wr(8'h48, 32'h1); rd(8'h48, d); chk("R6 write one", d, 0);
    // R10 valid low ignored
    wr(8'h60, {4'b0, 12'h300, 16'b0});
    @(negedge clk); code_data[11:0] = 12'h010; @(posedge clk);
    rd(8'h48, d); chk("R10 no valid", d, 0);
    // R7 set and clear together
    @(negedge clk); code_valid[0] = 1; code_data[11:0] = 12'h2F0;
    reg_wr = 1; reg_addr = 8'h48; reg_wdata = 32'h10;
    @(posedge clk); @(negedge clk); code_valid[0] = 0; reg_wr = 0;
    rd(8'h48, d); chk("R7 set wins", d, 32'h10);
    // R8 partial enables
    wr(8'h44, 32'h01); chk("R8 masked", {31'b0, irq}, 0);
    wr(8'h44, 32'h10); chk("R8 enabled", {31'b0, irq}, 1);
    wr(8'h48, 32'h77);
    // R9 zero limits
    wr(8'h50, 0); wr(8'h60, 0);
    send(0, 12'h000); rd(8'h48, d); chk("R9 zero limits", d, 0);
    chk("R9 irq low", {31'b0, irq}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule